// File: doc/BRIEF.md
# Serial Input Capture Delay Calibrator

This block chooses the capture delay applied to serial data returning from a remote device. After a start pulse it tries four delay codes in ascending order, 0 to 3, which stand for 0, 2, 4 and 6 ns of added input delay. For each code it drives the code on its delay select output and then issues one read of a known probe register through a valid/ready request channel. It then waits for the read data on a valid/ready response channel and compares that data with a fixed expected word. A code whose read returns the expected word gets its bit set in a 4-bit pass map. A read that gets no response within a programmable number of cycles counts as a fail.

When all four codes have been tried, a fixed 16-entry table turns the pass map into the final code. The table picks a code inside a single unbroken run of passing codes. It rejects an empty map and a map whose passing codes are split by a gap. A valid pick is driven on the delay select. A rejected map raises the error flag and puts back the code that was selected before calibration started. A one-cycle done pulse marks the end of the run. The pass map and the error flag then hold their values until the next start.

Back-pressure rules: the request stays valid, with a constant address, until the receiver accepts it. The block holds its response-ready high only while it waits for the answer to its own request. The responder must not present data at any other time. The block does not time out while a request is waiting for acceptance.

Top module: `rx_delay_cal`

## Requirements
- R1: After reset the delay select is 0, done, error, the pass map and the request valid are all 0.
- R2: A start pulse in idle begins a run that tries the codes 0, 1, 2 and 3 in that order. The delay select shows the code under test before that code's request is presented, and it does not change until that request's response or timeout.
- R3: Exactly one read request is issued per code. It carries the address PROBE_ADDR. Once raised, request valid stays high with the same address until request ready is sampled high.
- R4: Response ready is high only while the block awaits a response, and never in the same cycle as request valid. A response counts as a pass when its data equals PATTERN (default 16'h5AA5). A pass for code i sets bit i of the pass map.
- R5: The wait window is wait_limit cycles, starting the cycle after the request is accepted. A value of 0 is taken as 1. A response in the last cycle of the window still counts. If no response arrives within the window, the code is recorded as a fail.
- R6: The final code depends on the pass map as follows: 1→0, 2→1, 3→0, 4→2, 6→1, 7→1, 8→3, 12→3, 14→2, 15→1. The maps 0, 5, 9, 10, 11 and 13 are rejected.
- R7: For an accepted map, the delay select takes the table's code and error is 0 when done pulses.
- R8: For a rejected map, error is 1 when done pulses, and the delay select returns to the value it had before start.
- R9: Done is high for exactly one cycle, one cycle after the last code's result. Error and the pass map hold until the next start.
- R10: A start pulse during a run is ignored. No extra request follows the run's done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin calibration (used only when idle) |
| wait_limit | input | TW | Response wait window in cycles (0 acts as 1) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Probe register address |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Block is awaiting a response |
| rsp_data | input | DW | Read response data |
| dly_sel | output | 2 | Capture delay code |
| pass_map | output | 4 | Per-code pass bits |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Pass map was rejected |

## Verification
A sequencer that lands in the wrong state shows up at the ports within one handshake. Examples are a wrong code order, a lost request or a request that never ends. The symptom is a delay select that differs from the expected code while a request is valid, or a request count that does not match. A wrong compare or a wrong timeout count shows as a wrong pass-map bit at the done pulse. The responder deliberately places responses in the last cycle of the window and withholds others. A table or restore fault shows on the delay select and error in the done cycle. Stray starts during a run are checked by watching request valid for quiet cycles after done.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  localparam int SEL_W = 2;
  localparam int NSET  = 1 << SEL_W;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } rdc_state_e;

  typedef struct packed {
    logic             ok;
    logic [SEL_W-1:0] sel;
  } rdc_pick_t;
endpackage

// File: rtl/rdc_window_map.sv
module rdc_window_map
  import rdc_pkg::*;
(
  input  logic [NSET-1:0] map,
  output rdc_pick_t       pick
);
  // R6: centre of one unbroken passing run, rejection otherwise
  always_comb begin
    pick = '{ok: 1'b1, sel: '0};
    case (map)
      4'd1:    pick.sel = 2'd0;
      4'd2:    pick.sel = 2'd1;
      4'd3:    pick.sel = 2'd0;
      4'd4:    pick.sel = 2'd2;
      4'd6:    pick.sel = 2'd1;
      4'd7:    pick.sel = 2'd1;
      4'd8:    pick.sel = 2'd3;
      4'd12:   pick.sel = 2'd3;
      4'd14:   pick.sel = 2'd2;
      4'd15:   pick.sel = 2'd1;
      default: pick.ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/rdc_wait_timer.sv
module rdc_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;
  logic [TW-1:0] lim_eff;

  assign lim_eff = (limit == '0) ? TW'(1) : limit;
  assign expired = run && (cnt >= lim_eff - TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (run) cnt <= cnt + TW'(1);
  end

  // R5
  timer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (cnt == '0));
endmodule

// File: rtl/rdc_seq.sv
module rdc_seq
  import rdc_pkg::*;
#(
  parameter int          DW      = 16,
  parameter logic [DW-1:0] PATTERN = 16'h5AA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_ready,
  input  logic             rsp_valid,
  input  logic [DW-1:0]    rsp_data,
  input  logic             expired,
  input  rdc_pick_t        pick,
  output logic             rd_valid,
  output logic             rsp_ready,
  output logic             tmr_clr,
  output logic             tmr_run,
  output logic [SEL_W-1:0] dly_sel,
  output logic [NSET-1:0]  pass_map,
  output logic             done,
  output logic             err
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NSET - 1);

  rdc_state_e       state;
  logic [SEL_W-1:0] idx, prev_sel;
  logic             got, step;

  assign rd_valid  = (state == ST_ISSUE);
  assign rsp_ready = (state == ST_WAIT);
  assign got       = rsp_ready && rsp_valid;
  assign step      = got || (rsp_ready && expired);
  assign tmr_run   = rsp_ready && !rsp_valid;
  assign tmr_clr   = !rsp_ready || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      prev_sel <= '0;
      dly_sel  <= '0;
      pass_map <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          prev_sel <= dly_sel;
          dly_sel  <= '0;
          idx      <= '0;
          pass_map <= '0;
          err      <= 1'b0;
          state    <= ST_ISSUE;
        end
        ST_ISSUE: if (rd_ready) state <= ST_WAIT;
        ST_WAIT: if (step) begin
          pass_map[idx] <= got && (rsp_data == PATTERN);
          if (idx == LAST) begin
            state <= ST_FINISH;
          end else begin
            idx     <= idx + SEL_W'(1);
            dly_sel <= idx + SEL_W'(1);
            state   <= ST_ISSUE;
          end
        end
        default: begin
          dly_sel <= pick.ok ? pick.sel : prev_sel;
          err     <= !pick.ok;
          done    <= 1'b1;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> $stable(dly_sel));
  // R4
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rsp_ready));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
endmodule

// File: rtl/rx_delay_cal.sv
module rx_delay_cal
  import rdc_pkg::*;
#(
  parameter int            AW         = 16,
  parameter int            DW         = 16,
  parameter int            TW         = 8,
  parameter logic [AW-1:0] PROBE_ADDR = 16'h0C0A,
  parameter logic [DW-1:0] PATTERN    = 16'h5AA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] wait_limit,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic [1:0]    dly_sel,
  output logic [3:0]    pass_map,
  output logic          done,
  output logic          err
);
  logic      expired, tmr_clr, tmr_run;
  rdc_pick_t pick;

  assign rd_addr = PROBE_ADDR;

  rdc_wait_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run),
    .limit(wait_limit), .expired(expired)
  );

  rdc_window_map u_map (.map(pass_map), .pick(pick));

  rdc_seq #(.DW(DW), .PATTERN(PATTERN)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_ready(rd_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .expired(expired),
    .pick(pick), .rd_valid(rd_valid), .rsp_ready(rsp_ready),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run), .dly_sel(dly_sel),
    .pass_map(pass_map), .done(done), .err(err)
  );
endmodule

// File: tb/sim_rx_delay_cal.sv
module sim_rx_delay_cal;
  localparam logic [15:0] PAT  = 16'h5AA5;
  localparam logic [15:0] ADDR = 16'h0C0A;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] wait_limit = 8'd2;
  logic rd_valid, rd_ready = 1'b0, rsp_valid = 1'b0, rsp_ready;
  logic [15:0] rd_addr, rsp_data = '0;
  logic [1:0] dly_sel;
  logic [3:0] pass_map;
  logic done, err;
  int total = 0, bad = 0, prev_sel = 0;

  always #10 clk = ~clk;

  rx_delay_cal u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_limit(wait_limit),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .dly_sel(dly_sel), .pass_map(pass_map), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R6 table as stated, -1 = rejected
  function automatic int exp_sel(input logic [3:0] m);
    case (m)
      4'd1: return 0;  4'd2: return 1;  4'd3: return 0;  4'd4: return 2;
      4'd6: return 1;  4'd7: return 1;  4'd8: return 3;  4'd12: return 3;
      4'd14: return 2; 4'd15: return 1;
      default: return -1;
    endcase
  endfunction

  task automatic respond(input logic [3:0] eye, input logic [3:0] drop,
                         input int lim, input bit late);
    int le = (lim == 0) ? 1 : lim;
    for (int k = 0; k < 4; k++) begin
      int s = $urandom % 3;
      int d = late ? le - 1 : $urandom % le;
      do @(negedge clk); while (!rd_valid);
      chk(dly_sel == 2'(k), "R2 code order", dly_sel, k);
      chk(rd_addr == ADDR, "R3 address", rd_addr, ADDR);
      for (int j = 0; j < s; j++) begin
        @(negedge clk);
        chk(rd_valid == 1'b1, "R3 valid held", rd_valid, 1);
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      if (!drop[k]) begin
        repeat (d) @(negedge clk);
        chk(rsp_ready == 1'b1 && rd_valid == 1'b0, "R4 awaiting", rsp_ready, 1);
        rsp_valid = 1'b1;
        rsp_data  = eye[k] ? PAT : PAT ^ 16'(1 + $urandom % 16'hFFFE);
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  endtask

  task automatic run(input logic [3:0] eye, input logic [3:0] drop,
                     input int lim, input bit late, input bit poke);
    logic [3:0] em = eye & ~drop;   // R4 R5 expected map
    int es = exp_sel(em);
    wait_limit = 8'(lim);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fork
      respond(eye, drop, lim, late);
      if (poke) begin
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    for (int c = 0; c < 40 && !done; c++) @(negedge clk);
    chk(done == 1'b1, "R9 done", done, 1);
    chk(pass_map == em, "R4 R5 pass map", pass_map, em);
    if (es < 0) begin
      chk(err == 1'b1, "R8 err", err, 1);
      chk(dly_sel == 2'(prev_sel), "R8 restore", dly_sel, prev_sel);
    end else begin
      chk(err == 1'b0, "R7 err", err, 0);
      chk(dly_sel == 2'(es), "R6 R7 pick", dly_sel, es);
      prev_sel = es;
    end
    @(negedge clk);
    chk(done == 1'b0, "R9 pulse width", done, 0);
    chk(pass_map == em, "R9 map held", pass_map, em);
    chk(err == (es < 0), "R9 err held", err, es < 0);
    if (poke)
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        chk(rd_valid == 1'b0, "R10 no extra run", rd_valid, 0);
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(dly_sel == 2'd0 && done == 1'b0 && err == 1'b0, "R1 reset outs", {dly_sel, done, err}, 0);
    chk(pass_map == 4'd0 && rd_valid == 1'b0, "R1 reset map", {pass_map, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(4'hF, 4'h0, 3, 1'b0, 1'b0);   // R6 full window -> 1
    run(4'b1100, 4'h0, 4, 1'b1, 1'b0); // R5 response in last cycle, R6 -> 3
    run(4'h0, 4'h0, 2, 1'b0, 1'b0);   // R8 empty
    run(4'b0101, 4'h0, 2, 1'b0, 1'b1); // R8 split, R10 poke
    run(4'hF, 4'b0001, 1, 1'b0, 1'b0); // R5 timeout code 0 -> 14 -> 2
    run(4'b0010, 4'h0, 0, 1'b1, 1'b0); // R5 limit 0 as 1 -> 1
    run(4'b1000, 4'b0111, 2, 1'b0, 1'b1); // R10, R6 -> 3
    for (int n = 0; n < 24; n++) begin
      logic [3:0] dr = '0;
      for (int b = 0; b < 4; b++) dr[b] = ($urandom % 4 == 0);
      run(4'($urandom), dr, 1 + $urandom % 6, ($urandom % 3 == 0), ($urandom % 4 == 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule